// File: doc/BRIEF.md
# Nine-Level Serial Frame Encoder

This block turns a nine-level quantiser word (0 to 8) into a serial bit stream at the master clock rate. Each level becomes one 8-bit frame in which the number of ones equals the level. The result is a quasi-multibit stream suited to driving a shift-register FIR output stage. A free-running phase counter splits the clock into 8-cycle frames. The level word and the three controls are captured at the last cycle of each frame and govern the whole of the frame that follows.

There are three options, each sampled per frame. Rotation moves the first one of the frame to a pseudo-random bit position that changes once per frame. Restriction drops the all-zeros and all-ones levels, so that every frame holds at least one one and at least one zero. Mute replaces the level with a fixed alternating mid-scale pattern. A saturation flag is raised for each frame whose level had to be clamped into the allowed range.

Top module: `pwm9_serializer`

## Requirements
- R1: A frame built from level L (0 to 8) holds exactly L ones across its 8 output bits, one bit per clock on `bit_out`.
- R2: After reset the phase counter starts at frame bit 0, and a new frame starts every 8 clocks. The level used for a frame is `level_in` if `level_valid` is high in the last cycle of the previous frame. Otherwise it is the last value captured with `level_valid`.
- R3: With `restrict_en` high, a level of 0 becomes 1, and levels of 8 and above become 7. `sat_flag` is 1 for each frame where this happens, so every such frame has at least one 1 and at least one 0.
- R4: With `rot_en` low, the L ones occupy the first L bit times of the frame (frame bits 0 to L-1) and the rest are 0.
- R5: With `rot_en` high, the L ones stay contiguous, wrapping modulo 8. Their start position is 3 bits of an 8-bit LFSR with taps x^8+x^6+x^5+x^4+1, which steps once per frame, so the start position varies from frame to frame.
- R6: With `mute` high, the frame is 1,0,1,0,1,0,1,0 (frame bit 0 first, four ones) whatever the level and the rotation, and `sat_flag` is 0.
- R7: Levels 9 to 15 are clamped to 8 (or to 7 under R3), and `sat_flag` is 1 for that frame.
- R8: `sat_flag` changes only at frame bit 0, and it is 0 for any in-range level.
- R9: During reset, and for the first frame after reset, `bit_out` and `sat_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one output bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| level_in | input | 4 | Quantiser level, 0..8 valid, 9..15 clamped |
| level_valid | input | 1 | Captures `level_in` this cycle |
| rot_en | input | 1 | Enables pseudo-random rotation of the frame start |
| restrict_en | input | 1 | Limits levels to 1..7 |
| mute | input | 1 | Forces the alternating mid-scale frame |
| bit_out | output | 1 | Serial output bit |
| sat_flag | output | 1 | High for a frame whose level was clamped |

## Verification
The table walks every in-range level edge (0, 1, mid-scale, 7, 8), and out-of-range codes with restriction both off and on. This separates a correct ones count from a clamp that is off by one or applied in the wrong mode. Mute vectors carry both valid and out-of-range levels, which shows that mute overrides both the pattern and the flag. A rotation run over many frames checks that the ones count and contiguity are kept while the start position changes. A hold test captures a level in the middle of a frame and then leaves `level_valid` low, which separates the held level from the live input.

// File: rtl/pwm9_pkg.sv
// Shared constants for the nine-level serial frame encoder.
// Assumes a frame length that is a power of two.
package pwm9_pkg;
    localparam int unsigned PWM_FRAME  = 8;
    localparam int unsigned PWM_LVL_W  = $clog2(PWM_FRAME + 1);
    localparam int unsigned PWM_ROT_W  = $clog2(PWM_FRAME);
    localparam int unsigned PRN_W      = 8;
    localparam logic [PRN_W-1:0] PRN_TAPS = 8'hB8;
    localparam logic [PRN_W-1:0] PRN_SEED = 8'h5A;
endpackage

// File: rtl/pwm9_phase_ctr.sv
// Frame phase counter: counts 0..FRAME_LEN-1 and flags the last bit.
// Assumes FRAME_LEN is a power of two; holds 0 in reset.
module pwm9_phase_ctr #(
    parameter int unsigned FRAME_LEN = 8,
    localparam int unsigned PH_W     = $clog2(FRAME_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output logic            last
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAME_LEN - 1);

    // advance one bit position per clock
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
    end

    assign last = (phase == PH_LAST);
endmodule

// File: rtl/pwm9_lfsr.sv
// Fibonacci LFSR stepped once per frame; exposes its low OUT_W bits.
// Assumes SEED is nonzero and TAPS gives a maximal-length sequence.
module pwm9_lfsr #(
    parameter int unsigned W        = 8,
    parameter logic [W-1:0] TAPS    = 8'hB8,
    parameter logic [W-1:0] SEED    = 8'h5A,
    parameter int unsigned OUT_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [OUT_W-1:0] value
);
    logic [W-1:0] state;
    logic         fb;

    assign fb = ^(state & TAPS);

    // shift in the feedback bit on each step
    always_ff @(posedge clk) begin
        if (!rst_n)    state <= SEED;
        else if (step) state <= {state[W-2:0], fb};
    end

    assign value = state[OUT_W-1:0];
endmodule

// File: rtl/pwm9_pattern.sv
// Combinational frame builder: clamps the level, forms a thermometer
// code, rotates it by the offset and substitutes the mute pattern.
// Assumes FRAME_LEN is an even power of two.
module pwm9_pattern #(
    parameter int unsigned FRAME_LEN = 8,
    localparam int unsigned LVL_W    = $clog2(FRAME_LEN + 1),
    localparam int unsigned ROT_W    = $clog2(FRAME_LEN)
) (
    input  logic [LVL_W-1:0]     level,
    input  logic                 restrict_en,
    input  logic                 mute,
    input  logic                 rot_en,
    input  logic [ROT_W-1:0]     offset,
    output logic [FRAME_LEN-1:0] pattern,
    output logic                 sat
);
    localparam logic [LVL_W-1:0] HI_FULL = LVL_W'(FRAME_LEN);
    localparam logic [LVL_W-1:0] HI_RES  = LVL_W'(FRAME_LEN - 1);
    localparam logic [LVL_W-1:0] LO_RES  = LVL_W'(1);

    logic [LVL_W-1:0]     lvl_c;
    logic [LVL_W-1:0]     hi;
    logic                 clip;
    logic [ROT_W-1:0]     off_eff;
    logic [FRAME_LEN-1:0] therm;
    logic [FRAME_LEN-1:0] rotated;
    logic [FRAME_LEN-1:0] alt;

    // clamp the level into the range the current mode allows
    always_comb begin
        hi    = restrict_en ? HI_RES : HI_FULL;
        lvl_c = level;
        clip  = 1'b0;
        if (level > hi) begin
            lvl_c = hi;
            clip  = 1'b1;
        end else if (restrict_en && (level < LO_RES)) begin
            lvl_c = LO_RES;
            clip  = 1'b1;
        end
    end

    assign off_eff = rot_en ? offset : '0;

    genvar gi;
    generate
        for (gi = 0; gi < FRAME_LEN; gi++) begin : g_bit
            logic [ROT_W-1:0] src;
            assign therm[gi]   = (LVL_W'(gi) < lvl_c);
            assign src         = ROT_W'(gi) - off_eff;
            assign rotated[gi] = therm[src];
            assign alt[gi]     = ((gi % 2) == 0);
        end
    endgenerate

    assign pattern = mute ? alt : rotated;
    assign sat     = clip & ~mute;
endmodule

// File: rtl/pwm9_serializer.sv
// Nine-level serial frame encoder top. Captures the level and controls
// at the last bit of each frame, loads the next frame pattern and
// shifts it out one bit per clock. Assumes level_valid is pulsed about
// once per frame by the quantiser.
module pwm9_serializer #(
    parameter int unsigned FRAME_LEN = pwm9_pkg::PWM_FRAME,
    parameter int unsigned PRN_W     = pwm9_pkg::PRN_W,
    parameter logic [PRN_W-1:0] PRN_TAPS = pwm9_pkg::PRN_TAPS,
    parameter logic [PRN_W-1:0] PRN_SEED = pwm9_pkg::PRN_SEED,
    localparam int unsigned LVL_W    = $clog2(FRAME_LEN + 1),
    localparam int unsigned ROT_W    = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level_in,
    input  logic             level_valid,
    input  logic             rot_en,
    input  logic             restrict_en,
    input  logic             mute,
    output logic             bit_out,
    output logic             sat_flag
);
    logic [ROT_W-1:0]     phase;
    logic                 frame_last;
    logic [ROT_W-1:0]     prn_off;
    logic [LVL_W-1:0]     level_hold;
    logic [LVL_W-1:0]     level_sel;
    logic [FRAME_LEN-1:0] pat_next;
    logic                 sat_next;
    logic [FRAME_LEN-1:0] pat_q;
    logic                 sat_q;

    pwm9_phase_ctr #(.FRAME_LEN(FRAME_LEN)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .last  (frame_last)
    );

    pwm9_lfsr #(.W(PRN_W), .TAPS(PRN_TAPS), .SEED(PRN_SEED), .OUT_W(ROT_W)) u_prn (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (frame_last),
        .value (prn_off)
    );

    // keep the most recently presented level
    always_ff @(posedge clk) begin
        if (!rst_n)           level_hold <= '0;
        else if (level_valid) level_hold <= level_in;
    end

    assign level_sel = level_valid ? level_in : level_hold;

    pwm9_pattern #(.FRAME_LEN(FRAME_LEN)) u_pat (
        .level       (level_sel),
        .restrict_en (restrict_en),
        .mute        (mute),
        .rot_en      (rot_en),
        .offset      (prn_off),
        .pattern     (pat_next),
        .sat         (sat_next)
    );

    // load the next frame at the frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_q <= '0;
            sat_q <= 1'b0;
        end else if (frame_last) begin
            pat_q <= pat_next;
            sat_q <= sat_next;
        end
    end

    assign bit_out  = pat_q[phase];
    assign sat_flag = sat_q;
endmodule

// File: rtl/pwm9_serializer_chk.sv
// Property checker for pwm9_serializer, bound to every instance.
// Assumes the top's internal phase and frame register names.
module pwm9_serializer_chk #(
    parameter int unsigned FRAME_LEN = 8,
    localparam int unsigned ROT_W    = $clog2(FRAME_LEN)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ROT_W-1:0]     phase,
    input logic [FRAME_LEN-1:0] pat_q,
    input logic                 sat_flag,
    input logic                 restrict_en,
    input logic                 rot_en,
    input logic                 mute
);
    localparam logic [ROT_W-1:0]     PH_LAST = ROT_W'(FRAME_LEN - 1);
    localparam logic [FRAME_LEN-1:0] ALT     = {(FRAME_LEN/2){2'b01}};

    logic seen_wrap;

    // note that at least one frame boundary has passed since reset
    always_ff @(posedge clk) begin
        if (!rst_n)              seen_wrap <= 1'b0;
        else if (phase == PH_LAST) seen_wrap <= 1'b1;
    end

    p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LAST) |=> (phase == '0));

    p_phase_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_LAST) |=> (phase == $past(phase) + 1'b1));

    p_mixed_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_wrap && phase == '0 && $past(restrict_en) && !$past(mute))
        |-> (pat_q != '0 && pat_q != '1));

    p_plain_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_wrap && phase == '0 && !$past(rot_en) && !$past(mute))
        |-> (pat_q[0] || pat_q == '0));

    p_mute_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_wrap && phase == '0 && $past(mute))
        |-> (pat_q == ALT && !sat_flag));

    p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != '0) |-> $stable(sat_flag));

    p_frame_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != '0) |-> $stable(pat_q));
endmodule

bind pwm9_serializer pwm9_serializer_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase),
    .pat_q       (pat_q),
    .sat_flag    (sat_flag),
    .restrict_en (restrict_en),
    .rot_en      (rot_en),
    .mute        (mute)
);

// File: tb/pwm9_serializer_bench.sv
`timescale 1ns/1ps
// Bench for pwm9_serializer: table walk, then directed cases.
module pwm9_serializer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] level_in = '0;
    logic       level_valid = 1'b0;
    logic       rot_en = 1'b0;
    logic       restrict_en = 1'b0;
    logic       mute = 1'b0;
    logic       bit_out;
    logic       sat_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pwm9_serializer u_pwm9_serializer (
        .clk(clk), .rst_n(rst_n), .level_in(level_in), .level_valid(level_valid),
        .rot_en(rot_en), .restrict_en(restrict_en), .mute(mute),
        .bit_out(bit_out), .sat_flag(sat_flag)
    );

    // fields: level[14:11] restrict[10] mute[9] pattern[8:1] sat[0]
    localparam logic [14:0] VEC [0:13] = '{
        {4'd0,  1'b0, 1'b0, 8'h00, 1'b0},   // R1 R4
        {4'd1,  1'b0, 1'b0, 8'h01, 1'b0},   // R1 R4
        {4'd4,  1'b0, 1'b0, 8'h0F, 1'b0},   // R1 R4
        {4'd7,  1'b0, 1'b0, 8'h7F, 1'b0},   // R1
        {4'd8,  1'b0, 1'b0, 8'hFF, 1'b0},   // R1 R8
        {4'd12, 1'b0, 1'b0, 8'hFF, 1'b1},   // R7
        {4'd0,  1'b1, 1'b0, 8'h01, 1'b1},   // R3
        {4'd8,  1'b1, 1'b0, 8'h7F, 1'b1},   // R3
        {4'd5,  1'b1, 1'b0, 8'h1F, 1'b0},   // R3 in range
        {4'd15, 1'b1, 1'b0, 8'h7F, 1'b1},   // R7 with R3
        {4'd3,  1'b0, 1'b1, 8'h55, 1'b0},   // R6
        {4'd9,  1'b0, 1'b1, 8'h55, 1'b0},   // R6 over R7
        {4'd2,  1'b0, 1'b0, 8'h03, 1'b0},   // R1
        {4'd6,  1'b1, 1'b0, 8'h3F, 1'b0}    // R3
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Entered at a falling edge in frame bit 7; leaves there one frame later.
    task automatic run_frame(input bit valid, input logic [3:0] lvl, input bit rs,
                             input bit rt, input bit mt,
                             output logic [7:0] pat, output logic sat);
        level_in = lvl; level_valid = valid; restrict_en = rs; rot_en = rt; mute = mt;
        for (int p = 0; p < 8; p++) begin
            @(negedge clk);
            if (p == 0) begin
                level_valid = 1'b0;
                sat = sat_flag;
            end
            pat[p] = bit_out;
            if (p > 0 && sat_flag != sat)
                chk(1'b0, "R8 sat changed mid-frame", sat_flag, sat);
        end
    endtask

    function automatic int ones(input logic [7:0] v);
        int c = 0;
        for (int i = 0; i < 8; i++) c += v[i];
        return c;
    endfunction

    function automatic int rises(input logic [7:0] v);
        int c = 0;
        for (int i = 0; i < 8; i++) if (v[i] && !v[(i + 7) % 8]) c++;
        return c;
    endfunction

    function automatic int start_of(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i] && !v[(i + 7) % 8]) return i;
        return -1;
    endfunction

    initial begin
        logic [7:0] pat;
        logic       sat;
        logic [7:0] seen;
        int         distinct;

        // R9: reset state
        repeat (3) @(negedge clk);
        chk(bit_out == 1'b0 && sat_flag == 1'b0, "R9 in reset", {bit_out, sat_flag}, 0);
        rst_n = 1'b1;
        pat = '0;
        for (int p = 0; p < 8; p++) begin
            if (p > 0) @(negedge clk);
            #0.1;
            pat[p] = bit_out | sat_flag;
        end
        chk(pat == 8'h00, "R9 first frame", pat, 8'h00);

        // table walk, rotation off
        for (int i = 0; i < 14; i++) begin
            run_frame(1'b1, VEC[i][14:11], VEC[i][10], 1'b0, VEC[i][9], pat, sat);
            chk(pat == VEC[i][8:1], $sformatf("R1/R4 vector %0d pattern", i), pat, VEC[i][8:1]);
            chk(sat == VEC[i][0], $sformatf("R7/R8 vector %0d sat", i), sat, VEC[i][0]);
        end

        // R2: a level held from mid-frame capture
        run_frame(1'b1, 4'd2, 1'b0, 1'b0, 1'b0, pat, sat);
        run_frame(1'b0, 4'd7, 1'b0, 1'b0, 1'b0, pat, sat);
        chk(pat == 8'h03, "R2 held level", pat, 8'h03);
        level_in = 4'd1; level_valid = 1'b0;
        repeat (3) @(negedge clk);
        level_in = 4'd6; level_valid = 1'b1;
        @(negedge clk);
        level_valid = 1'b0; level_in = 4'd1;
        repeat (4) @(negedge clk);
        run_frame(1'b0, 4'd1, 1'b0, 1'b0, 1'b0, pat, sat);
        chk(pat == 8'h3F, "R2 mid-frame capture", pat, 8'h3F);

        // R5: rotation keeps count and contiguity, start varies
        seen = '0;
        for (int f = 0; f < 16; f++) begin
            run_frame(1'b1, 4'd3, 1'b0, 1'b1, 1'b0, pat, sat);
            chk(ones(pat) == 3 && rises(pat) == 1, "R5 rotated frame shape", pat, 3);
            if (start_of(pat) >= 0) seen[start_of(pat)] = 1'b1;
        end
        distinct = ones(seen);
        chk(distinct >= 2, "R5 start position varies", distinct, 2);

        // R3 with R5: restricted zero level under rotation
        run_frame(1'b1, 4'd0, 1'b1, 1'b1, 1'b0, pat, sat);
        chk(ones(pat) == 1 && sat == 1'b1, "R3 rotated restricted zero", {sat, pat}, 9'h101);

        // R6: mute ignores rotation
        run_frame(1'b1, 4'd8, 1'b0, 1'b1, 1'b1, pat, sat);
        chk(pat == 8'h55 && sat == 1'b0, "R6 mute with rotation", pat, 8'h55);

        // R9: reset mid-stream clears output
        run_frame(1'b1, 4'd8, 1'b0, 1'b0, 1'b0, pat, sat);
        run_frame(1'b1, 4'd9, 1'b0, 1'b0, 1'b0, pat, sat);
        rst_n = 1'b0;
        @(negedge clk);
        chk(bit_out == 1'b0 && sat_flag == 1'b0, "R9 reset mid-stream", {bit_out, sat_flag}, 0);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule